// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a stream of input clock cycles by a programmable ratio N = P·B + A. A prescaler divides the input cycles by either P+1 or P. A 5-bit swallow count selects the larger modulus for the first A prescaler periods of each output period. A 13-bit main count sets the total number of prescaler periods, B. P is fixed at build time and is either 8 or 32. For example, with P = 32 a ratio of 1000 is set as B = 31, A = 8.

Input cycles are marked by a clock enable. The swallow and main settings are captured into a register stage on every clock. The counters reload from that stage only when an output period ends, so a period never mixes two settings. At each period boundary the block emits a pulse one clock wide. A combinational check on the captured settings raises an error flag for an illegal setting. The divider refuses to start a period with an illegal setting and waits until the setting becomes legal.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a legal setting and the enable held high, `div_pulse` rises exactly once every P·B + A clocks (A = `swallow_in`, B = `main_in`). For example, P = 32, B = 31, A = 8 gives 1000 clocks, and P = 8, B = 20, A = 7 gives 167 clocks.
- R2: In each output period the prescaler runs at modulus P+1 for the first A prescaler periods and at modulus P for the rest. When A = B, every period uses P+1, and the ratio is B·(P+1).
- R3: `div_pulse` is high for exactly one clock per output period and never for two clocks in a row.
- R4: `cfg_err` is 1 when the captured setting has B < 3, or A > B, or A above the swallow limit. The swallow limit is 7 for P = 8 and 31 for P = 32. B = 8191 with A = 31 is legal.
- R5: `cfg_err` reflects a change on `swallow_in`/`main_in` one clock after that change, through the input register stage.
- R6: A setting changed in the middle of an output period does not alter that period. It takes effect from the next period onward.
- R7: Synchronous reset (`rst` high) holds `div_pulse` low and clears the counters. The first enabled cycle after reset loads the setting, and the first pulse then follows N further enabled cycles, that is, N+1 clocks after reset release with the enable high.
- R8: If the setting captured at a load or reload point is illegal, the counters are not loaded and no pulses follow. Every later enabled cycle retries the load, and counting resumes once the captured setting is legal.
- R9: Clocks with `en` low are not counted. With `en` high on every second clock, the pulse spacing is 2·N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Marks an input cycle to be divided |
| swallow_in | input | 5 | Swallow count A |
| main_in | input | 13 | Main count B |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| cfg_err | output | 1 | Captured setting is illegal |

## Verification
`cfg_err` is due one clock after the inputs move, so the bench drives the setting on a falling edge and reads the flag on the next falling edge. Pulse timing is measured by counting falling edges, after the rising edge that registers each event. The first pulse comes N+1 edges after reset release, and each later pulse N edges after the one before. A setting restored from an illegal value costs two extra edges: one for the input register and one for the load. A setting changed on the falling edge of a pulse is checked to appear only in the second interval after it.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  localparam int SW_W    = 5;
  localparam int MAIN_W  = 13;
  localparam int RATIO_W = 20;
  localparam int MAIN_MIN = 3;

  // Largest swallow count the prescaler option tolerates
  function automatic int swallow_limit(input int p);
    return (p <= 8) ? 7 : 31;
  endfunction

  // Overall ratio of one output period
  function automatic logic [RATIO_W-1:0] total_ratio(input int p,
                                                     input logic [SW_W-1:0] a,
                                                     input logic [MAIN_W-1:0] b);
    logic [RATIO_W-1:0] pw;
    pw = RATIO_W'(p);
    return pw * RATIO_W'(b) + RATIO_W'(a);
  endfunction

  // True for settings the divider must not run with
  function automatic logic setting_bad(input int p,
                                       input logic [SW_W-1:0] a,
                                       input logic [MAIN_W-1:0] b);
    logic too_small, a_over_b, a_over_lim;
    too_small  = (int'(b) < MAIN_MIN);
    a_over_b   = (a > SW_W'(0)) && (int'(a) > int'(b));
    a_over_lim = (int'(a) > swallow_limit(p));
    return too_small || a_over_b || a_over_lim;
  endfunction

endpackage

// File: rtl/pswallow_cfg_reg.sv
module pswallow_cfg_reg
  import pswallow_pkg::*;
#(
  parameter int P = 32
) (
  input  logic              clk,
  input  logic [SW_W-1:0]   a_in,
  input  logic [MAIN_W-1:0] b_in,
  output logic [SW_W-1:0]   a_q,
  output logic [MAIN_W-1:0] b_q,
  output logic              bad
);

  always_ff @(posedge clk) begin
    a_q <= a_in;
    b_q <= b_in;
  end

  always_comb bad = setting_bad(P, a_q, b_q);

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int P = 32,
  localparam int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wide_mode,
  output logic [CW-1:0] cnt,
  output logic          tick
);

  logic [CW-1:0] last;

  always_comb begin
    last = wide_mode ? CW'(P) : CW'(P - 1);
    tick = run && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (run)  cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters
  import pswallow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SW_W-1:0]   a_q,
  input  logic [MAIN_W-1:0] b_q,
  input  logic              bad,
  input  logic              tick,
  output logic              primed,
  output logic [SW_W-1:0]   a_rem,
  output logic [MAIN_W-1:0] b_rem,
  output logic              wide_mode,
  output logic              load_evt,
  output logic              term_evt,
  output logic              pulse
);

  always_comb begin
    wide_mode = (a_rem != '0);
    load_evt  = en && !primed && !bad;
    term_evt  = tick && (b_rem == MAIN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      a_rem  <= '0;
      b_rem  <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= term_evt;
      if (load_evt) begin
        primed <= 1'b1;
        a_rem  <= a_q;
        b_rem  <= b_q;
      end else if (term_evt) begin
        if (bad) begin
          primed <= 1'b0;
          a_rem  <= '0;
          b_rem  <= '0;
        end else begin
          a_rem <= a_q;
          b_rem <= b_q;
        end
      end else if (tick) begin
        b_rem <= b_rem - MAIN_W'(1);
        if (wide_mode) a_rem <= a_rem - SW_W'(1);
      end
    end
  end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pswallow_pkg::*;
#(
  parameter int P = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SW_W-1:0]   swallow_in,
  input  logic [MAIN_W-1:0] main_in,
  output logic              div_pulse,
  output logic              cfg_err
);

  localparam int CW = $clog2(P + 1);

  logic [SW_W-1:0]   a_q;
  logic [MAIN_W-1:0] b_q;
  logic              bad;
  logic              primed;
  logic [SW_W-1:0]   a_rem;
  logic [MAIN_W-1:0] b_rem;
  logic              wide_mode;
  logic              load_evt;
  logic              term_evt;
  logic              pre_tick;
  logic [CW-1:0]     pre_cnt;
  logic              run;

  assign run     = en && primed;
  assign cfg_err = bad;

  pswallow_cfg_reg #(.P(P)) cfg_i (
    .clk (clk),
    .a_in(swallow_in),
    .b_in(main_in),
    .a_q (a_q),
    .b_q (b_q),
    .bad (bad)
  );

  pswallow_prescaler #(.P(P)) pre_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .wide_mode(wide_mode),
    .cnt      (pre_cnt),
    .tick     (pre_tick)
  );

  pswallow_counters cnt_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .a_q      (a_q),
    .b_q      (b_q),
    .bad      (bad),
    .tick     (pre_tick),
    .primed   (primed),
    .a_rem    (a_rem),
    .b_rem    (b_rem),
    .wide_mode(wide_mode),
    .load_evt (load_evt),
    .term_evt (term_evt),
    .pulse    (div_pulse)
  );

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk
  import pswallow_pkg::*;
#(
  parameter int P = 32,
  localparam int CW = $clog2(P + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              primed,
  input logic              load_evt,
  input logic              term_evt,
  input logic              pre_tick,
  input logic [CW-1:0]     pre_cnt,
  input logic              wide_mode,
  input logic [SW_W-1:0]   a_q,
  input logic [MAIN_W-1:0] b_q,
  input logic [SW_W-1:0]   a_rem,
  input logic [MAIN_W-1:0] b_rem,
  input logic              div_pulse,
  input logic              cfg_err
);

  logic [RATIO_W-1:0] span_cnt;
  logic [RATIO_W-1:0] span_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      span_cnt <= '0;
      span_ref <= '0;
    end else if (load_evt || term_evt) begin
      span_cnt <= '0;
      span_ref <= total_ratio(P, a_q, b_q);
    end else if (en && primed) begin
      span_cnt <= span_cnt + RATIO_W'(1);
    end
  end

  // R1: each period ends after exactly P*B+A counted cycles
  assert_period_len_R1: assert property (@(posedge clk) disable iff (rst)
    term_evt |-> (span_cnt + RATIO_W'(1) == span_ref));

  // R2: prescaler count reaches P only in the wide modulus
  assert_wide_only_R2: assert property (@(posedge clk) disable iff (rst)
    (pre_cnt == CW'(P)) |-> wide_mode);

  // R2: swallow count moves only at prescaler outputs or loads
  assert_swallow_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(pre_tick || load_evt) |=> $stable(a_rem));

  // R3: single-clock pulse
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R3: a pulse always follows a period end
  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(term_evt));

  // R6: main count only changes at prescaler outputs or loads
  assert_main_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(pre_tick || load_evt) |=> $stable(b_rem));

  // R8: never load an illegal setting
  assert_no_bad_load_R8: assert property (@(posedge clk) disable iff (rst)
    load_evt |-> !cfg_err);

  // R9: idle cycles freeze the prescaler
  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pre_cnt));

endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.P(P)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .primed   (primed),
  .load_evt (load_evt),
  .term_evt (term_evt),
  .pre_tick (pre_tick),
  .pre_cnt  (pre_cnt),
  .wide_mode(wide_mode),
  .a_q      (a_q),
  .b_q      (b_q),
  .a_rem    (a_rem),
  .b_rem    (b_rem),
  .div_pulse(div_pulse),
  .cfg_err  (cfg_err)
);

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_hold = 1'b1;
  logic        en_toggle = 1'b0;
  logic        phase = 1'b0;
  logic        en;
  logic [4:0]  a_in = 5'd8;
  logic [12:0] b_in = 13'd31;
  logic [4:0]  a8_in = 5'd7;
  logic [12:0] b8_in = 13'd20;
  logic        pulse, err, pulse8, err8;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  assign en = en_toggle ? phase : en_hold;

  always #10 clk = ~clk;

  pulse_swallow_div #(.P(32)) dut_i (
    .clk(clk), .rst(rst), .en(en), .swallow_in(a_in), .main_in(b_in),
    .div_pulse(pulse), .cfg_err(err));

  pulse_swallow_div #(.P(8)) dut_p8_i (
    .clk(clk), .rst(rst), .en(en), .swallow_in(a8_in), .main_in(b8_in),
    .div_pulse(pulse8), .cfg_err(err8));

  // {A[4:0], B[12:0]} for the P=32 instance
  localparam logic [17:0] VEC [7] = '{
    {5'd8,  13'd31},
    {5'd0,  13'd3},
    {5'd3,  13'd3},
    {5'd2,  13'd5},
    {5'd0,  13'd10},
    {5'd31, 13'd31},
    {5'd31, 13'd200}
  };

  always @(negedge clk) begin
    phase <= ~phase;
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(input bit use8, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use8 ? pulse8 : pulse) && n < limit);
  endtask

  initial begin
    int n;
    int expn;

    // R7: reset holds the pulse low
    repeat (4) @(negedge clk);
    chk("R7 pulse low in reset", int'(pulse), 0);
    chk("R5 legal setting flag", int'(err), 0);

    // Table walk: R1 period, R7 first-pulse latency, R2 in A=B rows
    for (int i = 0; i < 7; i++) begin
      a_in = VEC[i][17:13];
      b_in = VEC[i][12:0];
      expn = 32 * int'(b_in) + int'(a_in);
      do_reset();
      wait_pulse(1'b0, 20000, n);
      chk($sformatf("R7 first pulse row %0d", i), n, expn + 1);
      wait_pulse(1'b0, 20000, n);
      if (a_in == b_in[4:0] && b_in < 13'd32)
        chk($sformatf("R2 wide-only period row %0d", i), n, int'(b_in) * 33);
      else
        chk($sformatf("R1 period row %0d", i), n, expn);
    end

    // R4 / R5: flag one clock after a change
    @(negedge clk); a_in = 5'd0; b_in = 13'd2;
    @(negedge clk); chk("R4 R5 B below 3", int'(err), 1);
    a_in = 5'd5; b_in = 13'd4;
    @(negedge clk); chk("R4 A above B", int'(err), 1);
    a_in = 5'd4; b_in = 13'd4;
    @(negedge clk); chk("R4 A equals B legal", int'(err), 0);
    a_in = 5'd31; b_in = 13'd8191;
    @(negedge clk); chk("R4 B max legal", int'(err), 0);
    a8_in = 5'd8; b8_in = 13'd20;
    @(negedge clk); chk("R4 A over P8 limit", int'(err8), 1);
    a8_in = 5'd7;
    @(negedge clk); chk("R4 A at P8 limit", int'(err8), 0);

    // R6: mid-run change lands only in the following period
    a_in = 5'd0; b_in = 13'd3;
    do_reset();
    wait_pulse(1'b0, 2000, n);
    a_in = 5'd3; b_in = 13'd5;
    wait_pulse(1'b0, 2000, n);
    chk("R6 current period keeps old ratio", n, 96);
    wait_pulse(1'b0, 2000, n);
    chk("R6 next period uses new ratio", n, 163);

    // R8: illegal setting parks the divider, recovery resumes
    a_in = 5'd0; b_in = 13'd2;
    wait_pulse(1'b0, 2000, n);
    chk("R8 period ends on old ratio", n, 163);
    wait_pulse(1'b0, 400, n);
    chk("R8 no pulse while illegal", int'(pulse), 0);
    a_in = 5'd0; b_in = 13'd3;
    wait_pulse(1'b0, 2000, n);
    chk("R8 restart latency", n, 98);

    // R9: enable on every second clock doubles the spacing
    a_in = 5'd3; b_in = 13'd3;
    do_reset();
    en_toggle = 1'b1;
    wait_pulse(1'b0, 4000, n);
    wait_pulse(1'b0, 4000, n);
    chk("R9 gated period", n, 198);
    en_toggle = 1'b0;

    // R1: P=8 instance, 8*20+7
    a8_in = 5'd7; b8_in = 13'd20;
    do_reset();
    wait_pulse(1'b1, 2000, n);
    chk("R7 P8 first pulse", n, 168);
    wait_pulse(1'b1, 2000, n);
    chk("R1 P8 period", n, 167);
    @(negedge clk);
    chk("R3 pulse one clock wide", int'(pulse8), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule